// File: doc/BRIEF.md
# Hermitian 2x2 Solve-and-Multiply Datapath

This block takes a stream of frequency bins and, for each one, returns w = F^-1 · e. Here F is a 2x2 Hermitian matrix and e is a two-element complex vector. Each bin brings five inputs, all signed Q1.15:

- the two real diagonal entries;
- the upper off-diagonal entry, which is complex;
- the two complex vector elements.

The lower off-diagonal entry is never an input. The block forms it as the complex conjugate of the upper entry. Because of this, the determinant is real, and the only division in the datapath is by a real number.

The inverse is never built or stored. In the cycle a bin is accepted, the block forms the real determinant and both adjugate-times-vector numerators directly. A sequential restoring divider then computes one reciprocal of the determinant's magnitude for that bin. Four scaling units multiply each numerator component by that reciprocal, then round and saturate the result back to Q1.15.

A determinant whose magnitude is zero or below a programmable threshold marks the bin as singular, and that bin returns zeros. Each result carries its bin number within a run of up to 64 bins and a flag on the final bin of the run. A valid/ready handshake on both sides keeps the bins in order, and a stalled output holds off the input.

Top module: `herm_inv_mul`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, ovf_sticky is 0 and the bin counter starts at 0.
- R2: For a non-singular bin, out_w0 equals (f11·e0 − f01·e1)/det, where det = f00·f11 − |f01|². The value is rounded to Q1.15 (value × 32768) and must lie within 2 LSB of the exact quotient.
- R3: out_w1 equals (f00·e1 − conj(f01)·e0)/det, within 2 LSB. The lower off-diagonal entry is the conjugate of in_f01, so flipping the sign of the imaginary part of in_f01 changes the result.
- R4: A negative determinant whose magnitude is at or above cfg_min_det is divided with its sign. The results follow R2 and R3 with no singular flag.
- R5: When det = 0, or |det| < cfg_min_det, the bin is singular. cfg_min_det is an unsigned integer in units of 2^-30. For a singular bin, all four outputs are 0 and out_singular is 1.
- R6: A result outside the Q1.15 range is clamped to +32767 or −32768. ovf_sticky then goes to 1 and stays at 1 until reset.
- R7: out_bin counts accepted bins 0, 1, …, cfg_bins−1 and then wraps to 0. cfg_bins is valid from 1 to 64. out_last is 1 exactly on the bin numbered cfg_bins−1.
- R8: One bin is in flight at a time. in_ready stays 0 from acceptance until the output handshake. While out_valid is 1 and out_ready is 0, every output holds steady and no new bin is accepted. Results leave in input order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_bins | input | 7 | Bins per run, 1 to 64 |
| cfg_min_det | input | 32 | Smallest accepted determinant magnitude, units 2^-30 |
| in_valid | input | 1 | Input bin present |
| in_ready | output | 1 | Block can accept a bin |
| in_f00 | input | 16 | First diagonal entry, real Q1.15 |
| in_f11 | input | 16 | Second diagonal entry, real Q1.15 |
| in_f01_re | input | 16 | Upper off-diagonal entry, real part |
| in_f01_im | input | 16 | Upper off-diagonal entry, imaginary part |
| in_e0_re | input | 16 | Vector element 0, real part |
| in_e0_im | input | 16 | Vector element 0, imaginary part |
| in_e1_re | input | 16 | Vector element 1, real part |
| in_e1_im | input | 16 | Vector element 1, imaginary part |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_w0_re | output | 16 | Result element 0, real part, Q1.15 |
| out_w0_im | output | 16 | Result element 0, imaginary part |
| out_w1_re | output | 16 | Result element 1, real part |
| out_w1_im | output | 16 | Result element 1, imaginary part |
| out_bin | output | 6 | Bin number of this result |
| out_last | output | 1 | Final bin of the run |
| out_singular | output | 1 | Determinant too small, outputs forced to zero |
| ovf_sticky | output | 1 | Some result was saturated since reset |

## Verification
Two functions can fall in the same cycle.

The first is the singular decision against the bin counter's wrap. A determinant exactly on the zero boundary, and one just under the threshold, are fed in on the bins that close a short run. The bench checks that out_singular and zero outputs come with the correct out_bin and out_last, and that the next bin restarts at 0.

The second is saturation against output backpressure. A bin whose quotient overflows is held with out_ready low while a further bin waits on the input. The bench checks three things:
- the clamped values and ovf_sticky stay frozen;
- in_ready stays low;
- the waiting bin emerges afterwards with its own result and the next bin number.

// File: rtl/herm_pkg.sv
package herm_pkg;
    localparam int DATA_W = 16;
    localparam int FRAC_W = DATA_W - 1;
    localparam int WIDE_W = 2 * DATA_W + 3;
    localparam int MAG_W  = 2 * DATA_W;

    typedef logic signed [DATA_W-1:0] sample_t;
    typedef logic signed [WIDE_W-1:0] wide_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DIV  = 2'd1,
        ST_OUT  = 2'd2
    } state_e;
endpackage

// File: rtl/herm_front.sv
module herm_front
    import herm_pkg::*;
(
    input  sample_t         a_i,
    input  sample_t         d_i,
    input  sample_t         br_i,
    input  sample_t         bi_i,
    input  sample_t         x0r_i,
    input  sample_t         x0i_i,
    input  sample_t         x1r_i,
    input  sample_t         x1i_i,
    output wide_t           det_o,
    output wide_t [3:0]     num_o
);
    wide_t a, d, br, bi, x0r, x0i, x1r, x1i;

    always_comb begin
        a   = WIDE_W'(a_i);
        d   = WIDE_W'(d_i);
        br  = WIDE_W'(br_i);
        bi  = WIDE_W'(bi_i);
        x0r = WIDE_W'(x0r_i);
        x0i = WIDE_W'(x0i_i);
        x1r = WIDE_W'(x1r_i);
        x1i = WIDE_W'(x1i_i);
        // real determinant: diagonal product minus |upper off-diagonal|^2
        det_o    = a * d - (br * br + bi * bi);
        // element 0: second diagonal times x0 minus upper term times x1
        num_o[0] = d * x0r - (br * x1r - bi * x1i);
        num_o[1] = d * x0i - (br * x1i + bi * x1r);
        // element 1: first diagonal times x1 minus conj(upper) times x0
        num_o[2] = a * x1r - (br * x0r + bi * x0i);
        num_o[3] = a * x1i - (br * x0i - bi * x0r);
    end
endmodule

// File: rtl/herm_recip_div.sv
module herm_recip_div #(
    parameter int MAG_W = 32,
    parameter int Q_W   = 51
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [MAG_W-1:0] divisor_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [Q_W-1:0]   quot_o
);
    localparam int CNT_W = $clog2(Q_W);
    localparam logic [CNT_W-1:0] TOP_BIT = CNT_W'(Q_W - 1);

    typedef struct packed {
        logic [MAG_W:0]   rem;
        logic [MAG_W-1:0] dvs;
        logic [Q_W-1:0]   quot;
        logic [CNT_W-1:0] cnt;
        logic             busy;
        logic             done;
    } div_t;

    div_t s_d, s_q;
    logic [MAG_W:0] shifted;

    always_comb begin
        s_d     = s_q;
        s_d.done = 1'b0;
        shifted = '0;
        if (start_i) begin
            s_d.rem  = '0;
            s_d.quot = '0;
            s_d.dvs  = divisor_i;
            s_d.cnt  = TOP_BIT;
            s_d.busy = 1'b1;
        end else if (s_q.busy) begin
            // dividend is a single one at the top quotient position
            shifted = {s_q.rem[MAG_W-1:0], (s_q.cnt == TOP_BIT)};
            if (shifted >= {1'b0, s_q.dvs}) begin
                s_d.rem  = shifted - {1'b0, s_q.dvs};
                s_d.quot = {s_q.quot[Q_W-2:0], 1'b1};
            end else begin
                s_d.rem  = shifted;
                s_d.quot = {s_q.quot[Q_W-2:0], 1'b0};
            end
            if (s_q.cnt == '0) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o = s_q.busy;
    assign done_o = s_q.done;
    assign quot_o = s_q.quot;

    // R2: a finished reciprocal leaves a remainder below the divisor
    a_r2_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (s_q.rem < {1'b0, s_q.dvs}));
    // R8: a new division is never launched over a running one
    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);
endmodule

// File: rtl/herm_scale_sat.sv
module herm_scale_sat
    import herm_pkg::*;
#(
    parameter int Q_W   = 51,
    parameter int SHIFT = 35
) (
    input  wide_t          num_i,
    input  logic [Q_W-1:0] recip_i,
    output sample_t        res_o,
    output logic           sat_o
);
    localparam int P_W = WIDE_W + Q_W + 1;
    localparam logic signed [P_W-1:0] HALF = P_W'(1) << (SHIFT - 1);
    localparam logic signed [P_W-1:0] MAXV = P_W'((1 << (DATA_W - 1)) - 1);
    localparam logic signed [P_W-1:0] MINV = -MAXV - P_W'(1);

    logic signed [P_W-1:0] prod, shf;

    always_comb begin
        prod = P_W'(num_i) * P_W'($signed({1'b0, recip_i}));
        shf  = (prod + HALF) >>> SHIFT;
        if (shf > MAXV) begin
            res_o = sample_t'(MAXV);
            sat_o = 1'b1;
        end else if (shf < MINV) begin
            res_o = sample_t'(MINV);
            sat_o = 1'b1;
        end else begin
            res_o = sample_t'(shf);
            sat_o = 1'b0;
        end
    end
endmodule

// File: rtl/herm_inv_mul.sv
module herm_inv_mul
    import herm_pkg::*;
#(
    parameter int MAX_BINS   = 64,
    parameter int RECIP_BITS = 50
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [$clog2(MAX_BINS):0]   cfg_bins,
    input  logic [2*DATA_W-1:0]         cfg_min_det,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [DATA_W-1:0]           in_f00,
    input  logic [DATA_W-1:0]           in_f11,
    input  logic [DATA_W-1:0]           in_f01_re,
    input  logic [DATA_W-1:0]           in_f01_im,
    input  logic [DATA_W-1:0]           in_e0_re,
    input  logic [DATA_W-1:0]           in_e0_im,
    input  logic [DATA_W-1:0]           in_e1_re,
    input  logic [DATA_W-1:0]           in_e1_im,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [DATA_W-1:0]           out_w0_re,
    output logic [DATA_W-1:0]           out_w0_im,
    output logic [DATA_W-1:0]           out_w1_re,
    output logic [DATA_W-1:0]           out_w1_im,
    output logic [$clog2(MAX_BINS)-1:0] out_bin,
    output logic                        out_last,
    output logic                        out_singular,
    output logic                        ovf_sticky
);
    localparam int IDX_W = $clog2(MAX_BINS);
    localparam int Q_W   = RECIP_BITS + 1;
    localparam int SHIFT = RECIP_BITS - FRAC_W;

    typedef struct packed {
        state_e              st;
        logic [IDX_W-1:0]    cnt;
        logic [IDX_W-1:0]    bin;
        logic                last;
        logic                sing;
        logic                ovf;
        wide_t [3:0]         num;
        sample_t [3:0]       w;
    } top_t;

    top_t r_d, r_q;

    wide_t          det;
    wide_t [3:0]    num_raw;
    logic [MAG_W-1:0] det_mag;
    logic           det_small;
    logic           div_start, div_busy, div_done;
    logic [Q_W-1:0] recip;
    sample_t [3:0]  w_scaled;
    logic [3:0]     w_sat;

    herm_front u_front (
        .a_i   (sample_t'(in_f00)),
        .d_i   (sample_t'(in_f11)),
        .br_i  (sample_t'(in_f01_re)),
        .bi_i  (sample_t'(in_f01_im)),
        .x0r_i (sample_t'(in_e0_re)),
        .x0i_i (sample_t'(in_e0_im)),
        .x1r_i (sample_t'(in_e1_re)),
        .x1i_i (sample_t'(in_e1_im)),
        .det_o (det),
        .num_o (num_raw)
    );

    herm_recip_div #(.MAG_W(MAG_W), .Q_W(Q_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (div_start),
        .divisor_i (det_mag),
        .busy_o    (div_busy),
        .done_o    (div_done),
        .quot_o    (recip)
    );

    for (genvar g = 0; g < 4; g++) begin : g_lane
        herm_scale_sat #(.Q_W(Q_W), .SHIFT(SHIFT)) u_scale (
            .num_i   (r_q.num[g]),
            .recip_i (recip),
            .res_o   (w_scaled[g]),
            .sat_o   (w_sat[g])
        );
    end

    always_comb begin
        r_d       = r_q;
        div_start = 1'b0;
        det_mag   = det[WIDE_W-1] ? MAG_W'(-det) : MAG_W'(det);
        det_small = (det == '0) || (det_mag < cfg_min_det);
        unique case (r_q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    for (int k = 0; k < 4; k++)
                        r_d.num[k] = det[WIDE_W-1] ? -num_raw[k] : num_raw[k];
                    r_d.bin  = r_q.cnt;
                    r_d.last = ({1'b0, r_q.cnt} >= cfg_bins - 1'b1);
                    r_d.cnt  = r_d.last ? '0 : r_q.cnt + 1'b1;
                    r_d.sing = det_small;
                    if (det_small) begin
                        r_d.w  = '0;
                        r_d.st = ST_OUT;
                    end else begin
                        div_start = 1'b1;
                        r_d.st    = ST_DIV;
                    end
                end
            end
            ST_DIV: begin
                if (div_done) begin
                    r_d.w   = w_scaled;
                    r_d.ovf = r_q.ovf | (|w_sat);
                    r_d.st  = ST_OUT;
                end
            end
            ST_OUT: begin
                if (out_ready) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign in_ready     = (r_q.st == ST_IDLE);
    assign out_valid    = (r_q.st == ST_OUT);
    assign out_w0_re    = r_q.w[0];
    assign out_w0_im    = r_q.w[1];
    assign out_w1_re    = r_q.w[2];
    assign out_w1_im    = r_q.w[3];
    assign out_bin      = r_q.bin;
    assign out_last     = r_q.last;
    assign out_singular = r_q.sing;
    assign ovf_sticky   = r_q.ovf;

    // R8: a stalled result keeps every field unchanged
    a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_w0_re) && $stable(out_w0_im)
            && $stable(out_w1_re) && $stable(out_w1_im) && $stable(out_bin)
            && $stable(out_singular) && $stable(out_last)));
    // R8: no acceptance while a result is pending
    a_r8_no_accept_pending: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);
    // R8: the divider only runs while the bin is in its division phase
    a_r8_div_only_in_phase: assert property (@(posedge clk) disable iff (!rst_n)
        div_busy |-> (r_q.st == ST_DIV));
    // R5: singular results are zero
    a_r5_singular_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_singular) |-> (out_w0_re == '0 && out_w0_im == '0
            && out_w1_re == '0 && out_w1_im == '0));
    // R6: the overflow flag never clears on its own
    a_r6_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_sticky |=> ovf_sticky);
    // R7: the last flag marks the final bin of the run
    a_r7_last_bin: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |-> ({1'b0, out_bin} == cfg_bins - 1'b1));
endmodule

// File: tb/test_herm_inv_mul.sv
module test_herm_inv_mul;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [6:0]  cfg_bins = 7'd64;
    logic [31:0] cfg_min_det = 32'd1 << 20;
    logic in_valid = 1'b0, in_ready;
    logic [15:0] f00 = '0, f11 = '0, f01r = '0, f01i = '0;
    logic [15:0] e0r = '0, e0i = '0, e1r = '0, e1i = '0;
    logic out_valid, out_ready = 1'b1;
    logic [15:0] w0r, w0i, w1r, w1i;
    logic [5:0] out_bin;
    logic out_last, out_singular, ovf_sticky;

    int n_chk = 0, n_bad = 0;
    int exp_bin = 0;
    int got[4];
    int got_bin, got_last, got_sing;

    always #2 clk = ~clk;

    herm_inv_mul i_herm_inv_mul (
        .clk(clk), .rst_n(rst_n), .cfg_bins(cfg_bins), .cfg_min_det(cfg_min_det),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_f00(f00), .in_f11(f11), .in_f01_re(f01r), .in_f01_im(f01i),
        .in_e0_re(e0r), .in_e0_im(e0i), .in_e1_re(e1r), .in_e1_im(e1i),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_w0_re(w0r), .out_w0_im(w0i), .out_w1_re(w1r), .out_w1_im(w1i),
        .out_bin(out_bin), .out_last(out_last), .out_singular(out_singular),
        .ovf_sticky(ovf_sticky)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int to_q15(input real r);
        real s;
        s = r * 32768.0;
        if (s >= 32767.0) return 32767;
        if (s <= -32768.0) return -32768;
        return (s >= 0.0) ? $rtoi(s + 0.5) : -$rtoi(-s + 0.5);
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // exact solve in floating point; order w0re, w0im, w1re, w1im
    task automatic ref_solve(input int a, d, br, bi, x0r, x0i, x1r, x1i, output int e[4]);
        real ra, rd, rbr, rbi, r0r, r0i, r1r, r1i, det;
        ra = a / 32768.0;  rd = d / 32768.0;  rbr = br / 32768.0; rbi = bi / 32768.0;
        r0r = x0r / 32768.0; r0i = x0i / 32768.0; r1r = x1r / 32768.0; r1i = x1i / 32768.0;
        det  = ra * rd - (rbr * rbr + rbi * rbi);
        e[0] = to_q15((rd * r0r - (rbr * r1r - rbi * r1i)) / det);
        e[1] = to_q15((rd * r0i - (rbr * r1i + rbi * r1r)) / det);
        e[2] = to_q15((ra * r1r - (rbr * r0r + rbi * r0i)) / det);
        e[3] = to_q15((ra * r1i - (rbr * r0i - rbi * r0r)) / det);
    endtask

    task automatic drive(input int a, d, br, bi, x0r, x0i, x1r, x1i);
        f00 = 16'(a); f11 = 16'(d); f01r = 16'(br); f01i = 16'(bi);
        e0r = 16'(x0r); e0i = 16'(x0i); e1r = 16'(x1r); e1i = 16'(x1i);
    endtask

    task automatic grab();
        got[0] = int'($signed(w0r)); got[1] = int'($signed(w0i));
        got[2] = int'($signed(w1r)); got[3] = int'($signed(w1i));
        got_bin = int'(out_bin); got_last = int'(out_last); got_sing = int'(out_singular);
    endtask

    // R7: bench-side run position of the bin just emitted
    task automatic check_index();
        int lastb;
        lastb = (exp_bin == int'(cfg_bins) - 1) ? 1 : 0;
        chk(got_bin == exp_bin, "R7 out_bin", got_bin, exp_bin);
        chk(got_last == lastb, "R7 out_last", got_last, lastb);
        exp_bin = lastb ? 0 : exp_bin + 1;
    endtask

    // one bin through the block with out_ready held high
    task automatic run_bin(input int a, d, br, bi, x0r, x0i, x1r, x1i);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        drive(a, d, br, bi, x0r, x0i, x1r, x1i);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        while (!out_valid) @(negedge clk);
        grab();
        check_index();
    endtask

    task automatic check_vals(input string req, input int a, d, br, bi, x0r, x0i, x1r, x1i);
        int e[4];
        ref_solve(a, d, br, bi, x0r, x0i, x1r, x1i, e);
        for (int k = 0; k < 4; k++)
            chk(iabs(got[k] - e[k]) <= 2, $sformatf("%s lane%0d", req, k), got[k], e[k]);
        chk(got_sing == 0, {req, " singular"}, got_sing, 0);
    endtask

    task automatic solve_and_check(input string req, input int a, d, br, bi, x0r, x0i, x1r, x1i);
        run_bin(a, d, br, bi, x0r, x0i, x1r, x1i);
        check_vals(req, a, d, br, bi, x0r, x0i, x1r, x1i);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        out_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_bin = 0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
        chk(ovf_sticky == 1'b0, "R1 ovf_sticky", int'(ovf_sticky), 0);
    endtask

    task automatic t_basic();
        solve_and_check("R2", 16384, 16384, 0, 0, 4096, -2048, 1000, 3000);
        solve_and_check("R2", 24576, 16384, 4096, 2048, 3000, 1000, -2000, 1500);
        solve_and_check("R2", 30000, 28000, -6000, 5000, -4000, 2500, 3500, -1200);
        chk(ovf_sticky == 1'b0, "R6 no saturation yet", int'(ovf_sticky), 0);
    endtask

    task automatic t_conj();
        // purely imaginary off-diagonal, only x0 nonzero: w1 imag sign reveals conjugation
        solve_and_check("R3", 24576, 24576, 0, 8192, 6000, 0, 0, 0);
        solve_and_check("R3", 24576, 24576, 0, -8192, 6000, 0, 0, 0);
        solve_and_check("R3", 20000, 26000, 3000, -7000, 1500, -2500, 800, 2200);
    endtask

    task automatic t_negdet();
        // det = 0.0625 - 0.25 < 0
        solve_and_check("R4", 8192, 8192, 16384, 0, 3277, 0, -1638, 0);
        solve_and_check("R4", 4096, 8192, 6000, 9000, 1000, -500, 700, 300);
    endtask

    task automatic t_singular();
        cfg_bins = 7'd3;
        do_reset();
        // bin 0: fine
        solve_and_check("R7", 16384, 16384, 0, 0, 1000, 0, 0, 1000);
        // bin 1: exact zero determinant
        run_bin(16384, 16384, 16384, 0, 5000, 100, -200, 3000);
        chk(got_sing == 1, "R5 zero det flag", got_sing, 1);
        for (int k = 0; k < 4; k++) chk(got[k] == 0, "R5 zero det output", got[k], 0);
        // bin 2 (last): |det| = 131056 < 2^20
        run_bin(16384, 16384, 16380, 0, 5000, 100, -200, 3000);
        chk(got_sing == 1, "R5 below threshold flag", got_sing, 1);
        for (int k = 0; k < 4; k++) chk(got[k] == 0, "R5 below threshold output", got[k], 0);
        // bin 0 again: |det| = 12435456 above threshold
        solve_and_check("R5 above threshold", 16384, 16384, 16000, 0, 100, 50, -80, 20);
        // zero determinant with a zero threshold still singular
        cfg_min_det = '0;
        run_bin(16384, 16384, 0, 16384, 100, 0, 0, 100);
        chk(got_sing == 1, "R5 zero det zero threshold", got_sing, 1);
        cfg_min_det = 32'd1 << 20;
        cfg_bins = 7'd64;
        do_reset();
    endtask

    task automatic t_index_wrap();
        cfg_bins = 7'd5;
        do_reset();
        for (int i = 0; i < 11; i++)
            solve_and_check("R7 run", 16384 + i * 100, 16384, 500, -300, 200 * i, 100, -150, 50);
        cfg_bins = 7'd1;
        do_reset();
        for (int i = 0; i < 2; i++)
            solve_and_check("R7 single", 16384, 20000, 0, 1000, 300, 300, 300, -300);
        cfg_bins = 7'd64;
        do_reset();
    endtask

    task automatic t_saturate_backpressure();
        int e[4];
        int held[4];
        // w0 = 8, w1 = -8 -> clamped
        out_ready = 1'b0;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        drive(2048, 2048, 0, 0, 16384, 0, -16384, 0);
        in_valid = 1'b1;
        @(negedge clk);
        // a second bin waits at the input during the stall
        drive(16384, 16384, 2000, 1000, 2000, -1000, 1500, 700);
        while (!out_valid) @(negedge clk);
        grab();
        held = got;
        chk(got[0] == 32767, "R6 clamp high", got[0], 32767);
        chk(got[2] == -32768, "R6 clamp low", got[2], -32768);
        chk(ovf_sticky == 1'b1, "R6 sticky set", int'(ovf_sticky), 1);
        check_index();
        repeat (6) @(negedge clk);
        chk(out_valid == 1'b1, "R8 stalled valid", int'(out_valid), 1);
        chk(in_ready == 1'b0, "R8 stalled ready", int'(in_ready), 0);
        chk(int'($signed(w0r)) == held[0], "R8 stalled hold", int'($signed(w0r)), held[0]);
        chk(int'($signed(w1r)) == held[2], "R8 stalled hold", int'($signed(w1r)), held[2]);
        out_ready = 1'b1;
        @(negedge clk);
        // the waiting bin is accepted at this edge; drop valid after it
        @(negedge clk);
        in_valid = 1'b0;
        while (!out_valid) @(negedge clk);
        grab();
        check_index();
        ref_solve(16384, 16384, 2000, 1000, 2000, -1000, 1500, 700, e);
        for (int k = 0; k < 4; k++)
            chk(iabs(got[k] - e[k]) <= 2, "R8 queued bin result", got[k], e[k]);
        solve_and_check("R2 after saturation", 20000, 20000, 1000, 0, 1000, 0, 0, 0);
        chk(ovf_sticky == 1'b1, "R6 sticky kept", int'(ovf_sticky), 1);
    endtask

    task automatic t_random();
        for (int i = 0; i < 120; i++) begin
            int a, d, br, bi, x[4];
            a  = int'($urandom_range(29491, 16384));
            d  = int'($urandom_range(29491, 16384));
            br = int'($urandom_range(19660, 0)) - 9830;
            bi = int'($urandom_range(19660, 0)) - 9830;
            for (int k = 0; k < 4; k++) x[k] = int'($urandom_range(1966, 0)) - 983;
            solve_and_check("R2 R3 random", a, d, br, bi, x[0], x[1], x[2], x[3]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_conj();
        t_negdet();
        t_singular();
        t_index_wrap();
        t_saturate_backpressure();
        t_random();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule